// File: doc/BRIEF.md
# Audio Function Group Power State Controller

This block holds the power state of the audio function group in a low-power codec and turns it into enable levels for the converters, mixer and port functions, port amplifiers, internal references, the link responder, the GPIO drivers and jack presence detect. Decoded set-power-state commands come in as a strobe with a target code. A second strobe carries a vendor command that selects one of two extra states below D3cold. A third strobe marks a function-group reset event.

Moving to a deeper state takes effect on the next clock. Moving to a shallower state starts a resume timer. The `ready` output is low while the timer runs, and the reported state changes only when the timer expires. The deadline depends on the state being left and is given in milliseconds, scaled by a cycles-per-millisecond parameter. The three deepest states ignore set-power-state requests to go shallower. They are left only through two function-group resets on consecutive cycles, which start the longest resume, back to D3.

Top module: `afg_power_ctl`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `pwr_state` is 3 (D3) and `ready` is 1.
- R2: State codes are 0=D0, 1=D1, 2=D2, 3=D3, 4=D3cold, 5=D4, 6=D5, and a larger code is a deeper state. A standard command with `cmd_state` above 4 is ignored. A vendor command selects D4 when `vnd_sel`=0 and D5 when `vnd_sel`=1. If strobes arrive in the same cycle, `fg_rst` wins over `vnd_valid`, which wins over `cmd_valid`.
- R3: A command whose target is deeper than the current state sets `pwr_state` to that target on the next cycle with `ready`=1. This also cancels any resume in progress.
- R4: A shallower command accepted in D0..D3 drops `ready` on the next cycle and leaves `pwr_state` unchanged. After exactly CLK_PER_MS*N cycles with `ready` low, `pwr_state` takes the target and `ready` returns to 1. N is D1_MS, D2_MS or D3_MS, chosen by the state being left.
- R5: While `ready` is low, shallower commands and commands to the current state are ignored. In D3cold, D4 and D5, all such commands are ignored.
- R6: A function-group reset in D0..D3 sets `pwr_state` to 3 on the next cycle with `ready`=1, and cancels any resume in progress.
- R7: In D3cold, D4 or D5, a reset on two consecutive cycles drops `ready` for exactly CLK_PER_MS*DEEP_MS cycles, after which `pwr_state` is 3. A lone reset has no effect, and a reset during that resume is ignored.
- R8: Enables {conv,mix,amp,ref,amp_lowpwr,link,gpio,pdet} are 11110111 in D0, 01110111 in D1 and 00110111 in D2.
- R9: The same enables are 00111111 in D3 and 00111110 in D3cold.
- R10: The same enables are 00111010 in D4 and 00000000 in D5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Standard set-power-state strobe |
| cmd_state | input | 3 | Target code for the standard command |
| vnd_valid | input | 1 | Vendor low-power command strobe |
| vnd_sel | input | 1 | 0 selects D4, 1 selects D5 |
| fg_rst | input | 1 | Function-group reset event |
| pwr_state | output | 3 | Actual power state code |
| ready | output | 1 | High when no resume is pending |
| conv_en | output | 1 | Converter enable |
| mix_en | output | 1 | Mixer and port function enable |
| amp_en | output | 1 | Port amplifier enable |
| ref_en | output | 1 | Internal reference enable |
| amp_lowpwr | output | 1 | Amplifiers and references in reduced-power mode |
| link_en | output | 1 | Link response enable |
| gpio_en | output | 1 | GPIO driver enable |
| pdet_en | output | 1 | Presence detect enable |

## Verification
The hardest case to reach is a resume that is interrupted. The stimulus has to wait a set number of cycles inside the timer window before it sends a reset or a deeper command, and then show that the state jumped with `ready` high. The same holds for proving that ignored requests inside a resume leave the timer's total length untouched. The bench counts every clock edge on which `ready` is low, so an injected command or reset that wrongly restarted or stalled the timer shows up as a wrong total. Paired resets in the deep states are driven on consecutive edges, and a lone reset is driven with an idle cycle around it.

// File: rtl/afg_power_ctl.sv
module afg_power_ctl #(
  parameter int unsigned CLK_PER_MS = 250000,
  parameter int unsigned D1_MS      = 1,
  parameter int unsigned D2_MS      = 2,
  parameter int unsigned D3_MS      = 10,
  parameter int unsigned DEEP_MS    = 200
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_valid,
  input  logic [2:0] cmd_state,
  input  logic       vnd_valid,
  input  logic       vnd_sel,
  input  logic       fg_rst,
  output logic [2:0] pwr_state,
  output logic       ready,
  output logic       conv_en,
  output logic       mix_en,
  output logic       amp_en,
  output logic       ref_en,
  output logic       amp_lowpwr,
  output logic       link_en,
  output logic       gpio_en,
  output logic       pdet_en
);
  localparam int unsigned LIM1 = CLK_PER_MS * D1_MS;
  localparam int unsigned LIM2 = CLK_PER_MS * D2_MS;
  localparam int unsigned LIM3 = CLK_PER_MS * D3_MS;
  localparam int unsigned LIMD = CLK_PER_MS * DEEP_MS;
  localparam int unsigned LMAX = (LIMD > LIM3) ? LIMD : LIM3;
  localparam int CW = $clog2(LMAX + 1);

  localparam logic [2:0] S_D0 = 3'd0;
  localparam logic [2:0] S_D1 = 3'd1;
  localparam logic [2:0] S_D2 = 3'd2;
  localparam logic [2:0] S_D3 = 3'd3;
  localparam logic [2:0] S_D3C = 3'd4;
  localparam logic [2:0] S_D4 = 3'd5;
  localparam logic [2:0] S_D5 = 3'd6;

  logic [2:0]    st, tgt, req_tgt;
  logic          busy, armed, req_v, deep, go_deeper, go_up;
  logic [CW-1:0] cnt, lim, up_lim;

  assign deep      = (st >= S_D3C);
  assign req_v     = vnd_valid | (cmd_valid & (cmd_state <= S_D3C));
  assign req_tgt   = vnd_valid ? (vnd_sel ? S_D5 : S_D4) : cmd_state;
  assign go_deeper = req_v & (req_tgt > st);
  assign go_up     = req_v & (req_tgt < st) & !deep & !busy;

  always_comb begin
    case (st)
      S_D1:    up_lim = CW'(LIM1);
      S_D2:    up_lim = CW'(LIM2);
      default: up_lim = CW'(LIM3);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= S_D3;
      tgt   <= S_D3;
      busy  <= 1'b0;
      armed <= 1'b0;
      cnt   <= '0;
      lim   <= '0;
    end else begin
      armed <= 1'b0;
      if (fg_rst && !deep) begin
        st   <= S_D3;
        busy <= 1'b0;
      end else if (fg_rst && deep && !busy) begin
        if (armed) begin
          busy <= 1'b1;
          cnt  <= '0;
          lim  <= CW'(LIMD);
          tgt  <= S_D3;
        end else begin
          armed <= 1'b1;
        end
      end else if (go_deeper) begin
        st   <= req_tgt;
        busy <= 1'b0;
      end else if (go_up) begin
        busy <= 1'b1;
        cnt  <= '0;
        lim  <= up_lim;
        tgt  <= req_tgt;
      end else if (busy) begin
        if (cnt == lim - 1'b1) begin
          st   <= tgt;
          busy <= 1'b0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  logic [7:0] en;
  always_comb begin
    case (st)
      S_D0:    en = 8'b1111_0111;
      S_D1:    en = 8'b0111_0111;
      S_D2:    en = 8'b0011_0111;
      S_D3:    en = 8'b0011_1111;
      S_D3C:   en = 8'b0011_1110;
      S_D4:    en = 8'b0011_1010;
      default: en = 8'b0000_0000;
    endcase
  end

  assign {conv_en, mix_en, amp_en, ref_en, amp_lowpwr, link_en, gpio_en, pdet_en} = en;
  assign pwr_state = st;
  assign ready     = !busy;
endmodule

module afg_power_ctl_chk (
  input logic       clk,
  input logic       rst,
  input logic       cmd_valid,
  input logic [2:0] cmd_state,
  input logic       vnd_valid,
  input logic       vnd_sel,
  input logic       fg_rst,
  input logic [2:0] pwr_state,
  input logic       ready,
  input logic       conv_en,
  input logic       link_en,
  input logic       gpio_en,
  input logic       amp_en,
  input logic       pdet_en
);
  // R1
  reset_state_chk: assert property (@(posedge clk) rst |=> (pwr_state == 3'd3 && ready));

  // R3
  cmd_deeper_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !vnd_valid && !fg_rst && cmd_state <= 3'd4 && cmd_state > pwr_state)
    |=> (pwr_state == $past(cmd_state) && ready));

  // R3
  vnd_deeper_chk: assert property (@(posedge clk) disable iff (rst)
    (vnd_valid && !fg_rst && (vnd_sel ? 3'd6 : 3'd5) > pwr_state)
    |=> (pwr_state == (vnd_sel ? 3'd6 : 3'd5) && ready));

  // R4
  resume_start_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !vnd_valid && !fg_rst && ready && pwr_state <= 3'd3 && cmd_state < pwr_state)
    |=> (!ready && $stable(pwr_state)));

  // R4
  state_move_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(pwr_state) |-> ready);

  // R6
  single_reset_chk: assert property (@(posedge clk) disable iff (rst)
    (fg_rst && pwr_state <= 3'd3) |=> (pwr_state == 3'd3 && ready));

  // R9
  deep_pdet_chk: assert property (@(posedge clk) disable iff (rst)
    (pwr_state >= 3'd4) |-> (!pdet_en && !conv_en));

  // R10
  d5_off_chk: assert property (@(posedge clk) disable iff (rst)
    (pwr_state == 3'd6) |-> (!gpio_en && !amp_en && !link_en));
endmodule

bind afg_power_ctl afg_power_ctl_chk u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_state(cmd_state),
  .vnd_valid(vnd_valid), .vnd_sel(vnd_sel), .fg_rst(fg_rst),
  .pwr_state(pwr_state), .ready(ready), .conv_en(conv_en), .link_en(link_en),
  .gpio_en(gpio_en), .amp_en(amp_en), .pdet_en(pdet_en)
);

// File: tb/afg_power_ctl_tb.sv
module afg_power_ctl_tb;
  localparam int unsigned CPM = 10;
  localparam int L1 = CPM * 1, L2 = CPM * 2, L3 = CPM * 10, LD = CPM * 200;

  logic clk = 0, rst = 1;
  logic cmd_valid = 0, vnd_valid = 0, vnd_sel = 0, fg_rst = 0;
  logic [2:0] cmd_state = 0;
  logic [2:0] pwr_state;
  logic ready, conv_en, mix_en, amp_en, ref_en, amp_lowpwr, link_en, gpio_en, pdet_en;
  int nchk = 0, nfail = 0, lowcnt = 0;

  always #2 clk = ~clk;
  always @(posedge clk) if (!ready) lowcnt <= lowcnt + 1;

  afg_power_ctl #(.CLK_PER_MS(CPM)) u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_state(cmd_state),
    .vnd_valid(vnd_valid), .vnd_sel(vnd_sel), .fg_rst(fg_rst),
    .pwr_state(pwr_state), .ready(ready), .conv_en(conv_en), .mix_en(mix_en),
    .amp_en(amp_en), .ref_en(ref_en), .amp_lowpwr(amp_lowpwr), .link_en(link_en),
    .gpio_en(gpio_en), .pdet_en(pdet_en));

  function automatic logic [7:0] exp_en(input logic [2:0] s);
    case (s)
      3'd0: return 8'b1111_0111;
      3'd1: return 8'b0111_0111;
      3'd2: return 8'b0011_0111;
      3'd3: return 8'b0011_1111;
      3'd4: return 8'b0011_1110;
      3'd5: return 8'b0011_1010;
      default: return 8'b0000_0000;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_state(input string req, input int s, input int rdy);
    chk(req, pwr_state, s);
    chk(req, ready, rdy);
  endtask

  task automatic chk_en(input string req);
    chk(req, {conv_en, mix_en, amp_en, ref_en, amp_lowpwr, link_en, gpio_en, pdet_en},
        exp_en(pwr_state));
  endtask

  task automatic issue(input logic cv, input logic [2:0] cs, input logic vv,
                       input logic vs, input logic fr);
    @(negedge clk);
    cmd_valid = cv; cmd_state = cs; vnd_valid = vv; vnd_sel = vs; fg_rst = fr;
    @(negedge clk);
    cmd_valid = 0; vnd_valid = 0; fg_rst = 0;
  endtask

  task automatic reset_pair();
    @(negedge clk); fg_rst = 1;
    @(negedge clk);
    @(negedge clk); fg_rst = 0;
  endtask

  task automatic wait_ready();
    for (int g = 0; g < 5000 && !ready; g++) @(negedge clk);
  endtask

  task automatic resume(input string req, input logic [2:0] to, input int lim);
    lowcnt = 0;
    issue(1, to, 0, 0, 0);
    chk(req, ready, 0);
    wait_ready();
    chk(req, lowcnt, lim);
    chk(req, pwr_state, to);
  endtask

  task automatic t_reset();
    chk_state("R1", 3, 1);
    chk_en("R9");
  endtask

  task automatic t_basic_resumes();
    resume("R4", 3'd0, L3);
    chk_en("R8");
    issue(1, 3'd2, 0, 0, 0);
    chk_state("R3", 2, 1);
    chk_en("R8");
    resume("R4", 3'd1, L2);
    chk_en("R8");
    resume("R4", 3'd0, L1);
  endtask

  task automatic t_ignored();
    issue(1, 3'd7, 0, 0, 0);
    chk_state("R2", 0, 1);
    issue(1, 3'd0, 0, 0, 0);
    chk_state("R5", 0, 1);
  endtask

  task automatic t_resume_interrupts();
    issue(1, 3'd3, 0, 0, 0);
    chk_state("R3", 3, 1);
    lowcnt = 0;
    issue(1, 3'd0, 0, 0, 0);
    repeat (20) @(negedge clk);
    issue(1, 3'd1, 0, 0, 0);
    chk_state("R5", 3, 0);
    wait_ready();
    chk("R5", lowcnt, L3);
    chk("R5", pwr_state, 0);
    issue(1, 3'd3, 0, 0, 0);
    issue(1, 3'd0, 0, 0, 0);
    repeat (30) @(negedge clk);
    issue(1, 3'd4, 0, 0, 0);
    chk_state("R3", 4, 1);
    chk_en("R9");
  endtask

  task automatic t_deep_exit();
    issue(1, 3'd0, 0, 0, 0);
    chk_state("R5", 4, 1);
    issue(0, 3'd0, 0, 0, 1);
    @(negedge clk);
    chk_state("R7", 4, 1);
    lowcnt = 0;
    reset_pair();
    chk_state("R7", 4, 0);
    repeat (100) @(negedge clk);
    issue(0, 3'd0, 0, 0, 1);
    wait_ready();
    chk("R7", lowcnt, LD);
    chk("R7", pwr_state, 3);
  endtask

  task automatic t_fg_reset();
    resume("R4", 3'd0, L3);
    issue(0, 3'd0, 0, 0, 1);
    chk_state("R6", 3, 1);
    issue(1, 3'd0, 0, 0, 0);
    repeat (10) @(negedge clk);
    issue(0, 3'd0, 0, 0, 1);
    chk_state("R6", 3, 1);
  endtask

  task automatic t_vendor();
    issue(1, 3'd4, 1, 0, 0);
    chk_state("R2", 5, 1);
    chk_en("R10");
    issue(1, 3'd3, 0, 0, 0);
    chk_state("R5", 5, 1);
    issue(0, 3'd0, 1, 1, 0);
    chk_state("R3", 6, 1);
    chk_en("R10");
    issue(0, 3'd0, 1, 0, 0);
    chk_state("R5", 6, 1);
    lowcnt = 0;
    reset_pair();
    wait_ready();
    chk("R7", lowcnt, LD);
    chk_state("R7", 3, 1);
    chk_en("R9");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk_state("R1", 3, 1);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_basic_resumes();
    t_ignored();
    t_resume_interrupts();
    t_deep_exit();
    t_fg_reset();
    t_vendor();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule